// File: doc/BRIEF.md
# Two-Slot Circular Packet Reader

This block sits between a packet memory and the transmit side of an SPI slave. It keeps a small ring of two packet slots, each `PKT_BYTES` bytes wide, and hands the bytes out one at a time over a valid/ready stream in address order. After the last byte it wraps back to the first. A producer fills the ring through a plain write port. Because the SPI slave must always have data ready when the master starts clocking, the block keeps streaming while the producer works. The producer is expected to write only the slot that the reader is not currently fetching from.

The reader signals each slot boundary with a one-cycle event. One event follows the last byte of the lower slot, and the other follows the last byte of the upper slot, where the ring wraps. It also reports the slot it is currently fetching from. A write into that active slot is still stored, but it raises a clash pulse. The SPI side may prefetch a few bytes, so the events mark the moment a byte leaves this memory. They do not mark the moment it reaches the wire.

The stream obeys back-pressure. `tx_valid` follows `enable`. While `tx_ready` is low, the read position and the offered byte hold. A byte is consumed only in a cycle where both `tx_valid` and `tx_ready` are high. Lowering `enable` takes the reader back to the start of the ring.

Top module: `ppr_reader`

## Requirements
- R1: After reset the read position is byte 0 and every memory byte is zero. `half_evt`, `cplt_evt`, `active_slot` and `wr_clash` are all low.
- R2: `tx_valid` equals `enable`, and `tx_data` is the byte at the read position. A cycle with `tx_valid` and `tx_ready` both high advances the position by one. With `tx_ready` low, the position and `tx_data` hold.
- R3: Bytes leave in address order 0 to 2*PKT_BYTES-1. After the last address the position wraps to 0.
- R4: `half_evt` is high for exactly one cycle, the cycle after the handshake of address PKT_BYTES-1. It is never high together with `cplt_evt`.
- R5: `cplt_evt` is high for exactly one cycle, the cycle after the handshake of address 2*PKT_BYTES-1. In that cycle the position is back at 0.
- R6: `active_slot` is 0 while the position is below PKT_BYTES and 1 otherwise.
- R7: When `wr_en` is high, `wr_data` is stored at `wr_addr`. The reader can see it from the next cycle on.
- R8: A write made while `enable` is high, whose address is in the active slot, is still stored. It makes `wr_clash` pulse high in the next cycle. A write to the other slot, or any write while `enable` is low, leaves `wr_clash` low.
- R9: While `enable` is low, `tx_valid` is low, `tx_ready` has no effect, no event pulses, and the position returns to byte 0 on the next cycle.
- R10: A slot written after the reader has left it is delivered whole, with the new bytes, on the next pass through the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the reader; low parks it at byte 0 |
| wr_en | input | 1 | Producer write strobe |
| wr_addr | input | AW | Producer byte address, below 2*PKT_BYTES |
| wr_data | input | DATA_W | Producer byte |
| tx_valid | output | 1 | A byte is offered |
| tx_ready | input | 1 | Consumer takes the offered byte |
| tx_data | output | DATA_W | Offered byte |
| active_slot | output | 1 | Slot of the read position |
| half_evt | output | 1 | Lower slot fully fetched |
| cplt_evt | output | 1 | Upper slot fully fetched, ring wrapped |
| wr_clash | output | 1 | Previous write hit the active slot |

## Verification
The bench builds the block with its defaults, `DATA_W` = 8 and `PKT_BYTES` = 4. That gives an eight-byte ring, so both slot events and the wrap back to zero come within a few handshakes. It drives several full passes with writes placed before and after each event. This puts the clash/no-clash split and the rule that an updated slot arrives whole on the next pass within a short run. It also disables the reader one byte before the half-way event, which shows that the event is suppressed and that the position restarts from zero.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  typedef enum logic {
    SLOT_LO = 1'b0,
    SLOT_HI = 1'b1
  } slot_e;

  function automatic slot_e slot_of(input int unsigned addr, input int unsigned pkt);
    return (addr >= pkt) ? SLOT_HI : SLOT_LO;
  endfunction
endpackage

// File: rtl/ppr_store.sv
module ppr_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && (int'(wr_addr) < DEPTH)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < DEPTH) rd_data = mem[rd_addr];
  end
endmodule

// File: rtl/ppr_cursor.sv
module ppr_cursor #(
  parameter int PKT_BYTES = 4,
  parameter int AW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          step,
  output logic [AW-1:0] ptr,
  output logic          half_evt,
  output logic          cplt_evt
);
  localparam logic [AW-1:0] LAST_LO = AW'(PKT_BYTES - 1);
  localparam logic [AW-1:0] LAST_HI = AW'(2 * PKT_BYTES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      half_evt <= 1'b0;
      cplt_evt <= 1'b0;
    end else begin
      half_evt <= 1'b0;
      cplt_evt <= 1'b0;
      if (!enable) begin
        ptr <= '0;
      end else if (step) begin
        if (ptr == LAST_HI) begin
          ptr      <= '0;
          cplt_evt <= 1'b1;
        end else begin
          ptr <= ptr + 1'b1;
          if (ptr == LAST_LO) half_evt <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ppr_clash.sv
module ppr_clash #(
  parameter int PKT_BYTES = 4,
  parameter int AW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          active_slot,
  output logic          wr_clash
);
  import ppr_pkg::*;

  slot_e wr_slot;
  assign wr_slot = slot_of(int'(wr_addr), PKT_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_clash <= 1'b0;
    else        wr_clash <= enable && wr_en && (wr_slot == slot_e'(active_slot));
  end
endmodule

// File: rtl/ppr_reader.sv
module ppr_reader #(
  parameter int DATA_W    = 8,
  parameter int PKT_BYTES = 4,
  parameter int AW        = $clog2(2 * PKT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              active_slot,
  output logic              half_evt,
  output logic              cplt_evt,
  output logic              wr_clash
);
  import ppr_pkg::*;

  localparam int DEPTH = 2 * PKT_BYTES;

  logic [AW-1:0] rd_ptr;
  logic          step;

  assign tx_valid    = enable;
  assign step        = tx_valid && tx_ready;
  assign active_slot = logic'(slot_of(int'(rd_ptr), PKT_BYTES));

  ppr_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_ptr), .rd_data(tx_data)
  );

  ppr_cursor #(.PKT_BYTES(PKT_BYTES), .AW(AW)) u_cursor (
    .clk(clk), .rst_n(rst_n), .enable(enable), .step(step),
    .ptr(rd_ptr), .half_evt(half_evt), .cplt_evt(cplt_evt)
  );

  ppr_clash #(.PKT_BYTES(PKT_BYTES), .AW(AW)) u_clash (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .wr_en(wr_en), .wr_addr(wr_addr), .active_slot(active_slot),
    .wr_clash(wr_clash)
  );
endmodule

// File: rtl/ppr_reader_chk.sv
module ppr_reader_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              wr_en,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              active_slot,
  input logic              half_evt,
  input logic              cplt_evt,
  input logic              wr_clash
);
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid && !tx_ready && !wr_en) |=> (!tx_valid || $stable(tx_data))); // R2
  AST_HALF_FROM_FIRE: assert property (@(posedge clk) disable iff (!rst_n) half_evt |-> $past(tx_valid && tx_ready)); // R4
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({half_evt, cplt_evt})); // R4
  AST_CPLT_FROM_FIRE: assert property (@(posedge clk) disable iff (!rst_n) cplt_evt |-> $past(tx_valid && tx_ready)); // R5
  AST_CPLT_AT_START: assert property (@(posedge clk) disable iff (!rst_n) cplt_evt |-> !active_slot); // R5
  AST_HALF_IN_UPPER: assert property (@(posedge clk) disable iff (!rst_n) half_evt |-> active_slot); // R6
  AST_CLASH_SRC: assert property (@(posedge clk) disable iff (!rst_n) wr_clash |-> $past(wr_en && enable)); // R8
  AST_OFF_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) !enable |-> !tx_valid); // R9
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !$past(enable) |-> (!half_evt && !cplt_evt)); // R9
endmodule

bind ppr_reader ppr_reader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .active_slot(active_slot), .half_evt(half_evt), .cplt_evt(cplt_evt),
  .wr_clash(wr_clash)
);

// File: tb/test_ppr_reader.sv
module test_ppr_reader;
  localparam int DW = 8;
  localparam int PB = 4;
  localparam int AW = $clog2(2 * PB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          tx_ready = 1'b0;
  logic          tx_valid, active_slot, half_evt, cplt_evt, wr_clash;
  logic [DW-1:0] tx_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ppr_reader #(.DATA_W(DW), .PKT_BYTES(PB)) i_ppr_reader (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .active_slot(active_slot), .half_evt(half_evt), .cplt_evt(cplt_evt),
    .wr_clash(wr_clash)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic take(input logic [DW-1:0] exp, input string req);
    chk(req, "tx_valid", int'(tx_valid), 1);
    chk(req, "tx_data", int'(tx_data), int'(exp));
    tx_ready = 1'b1;
    tick();
    tx_ready = 1'b0;
  endtask

  task automatic put(input int addr, input logic [DW-1:0] d, input int exp_clash, input string req);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = d;
    tick();
    wr_en = 1'b0;
    chk(req, "wr_clash", int'(wr_clash), exp_clash);
  endtask

  task automatic t_reset();
    chk("R1", "tx_valid", int'(tx_valid), 0);
    chk("R1", "half_evt", int'(half_evt), 0);
    chk("R1", "cplt_evt", int'(cplt_evt), 0);
    chk("R1", "active_slot", int'(active_slot), 0);
    chk("R1", "wr_clash", int'(wr_clash), 0);
    enable = 1'b1; #1;
    chk("R1", "byte0 zero", int'(tx_data), 0);
    enable = 1'b0; tick();
  endtask

  task automatic t_full_pass();
    for (int i = 0; i < 2 * PB; i++) put(i, DW'(8'h10 + i), 0, "R7");
    enable = 1'b1;
    for (int i = 0; i < 2 * PB; i++) begin
      take(DW'(8'h10 + i), "R3");
      chk("R4", "half_evt", int'(half_evt), (i == PB - 1) ? 1 : 0);
      chk("R5", "cplt_evt", int'(cplt_evt), (i == 2 * PB - 1) ? 1 : 0);
      chk("R6", "active_slot", int'(active_slot), (i >= PB - 1 && i < 2 * PB - 1) ? 1 : 0);
    end
    chk("R3", "wrapped byte0", int'(tx_data), 8'h10);
  endtask

  task automatic t_backpressure();
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R2", "held data", int'(tx_data), 8'h10);
      chk("R2", "held valid", int'(tx_valid), 1);
      chk("R2", "no event", int'(half_evt | cplt_evt), 0);
    end
  endtask

  task automatic t_clash();
    put(1, 8'hA1, 1, "R8");
    put(5, 8'hB5, 0, "R8");
    take(8'h10, "R8");
    take(8'hA1, "R8");
    take(8'h12, "R2");
    take(8'h13, "R4");
    chk("R4", "half after byte3", int'(half_evt), 1);
  endtask

  task automatic t_pingpong();
    for (int i = 0; i < PB; i++) put(i, 8'h50, 0, "R10");
    take(8'h14, "R10");
    take(8'hB5, "R8");
    take(8'h16, "R10");
    take(8'h17, "R10");
    chk("R5", "cplt", int'(cplt_evt), 1);
    for (int i = PB; i < 2 * PB; i++) put(i, 8'h51, 0, "R10");
    for (int i = 0; i < PB; i++) take(8'h50, "R10");
    chk("R4", "half", int'(half_evt), 1);
    for (int i = 0; i < PB; i++) take(8'h51, "R10");
    chk("R5", "cplt", int'(cplt_evt), 1);
  endtask

  task automatic t_disable();
    take(8'h50, "R9"); take(8'h50, "R9"); take(8'h50, "R9");
    enable = 1'b0; tx_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R9", "tx_valid off", int'(tx_valid), 0);
      chk("R9", "no half", int'(half_evt), 0);
      chk("R9", "no cplt", int'(cplt_evt), 0);
    end
    tx_ready = 1'b0; enable = 1'b1; #1;
    chk("R9", "active_slot restart", int'(active_slot), 0);
    for (int i = 0; i < PB; i++) begin
      take(8'h50, "R9");
      chk("R9", "half only after full slot", int'(half_evt), (i == PB - 1) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_full_pass();
    t_backpressure();
    t_clash();
    t_pingpong();
    t_disable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule